// File: doc/BRIEF.md
# Blit Parameter Register Front-End

This block sits between a host register bus and a 2D pixel-copy engine. The host writes source and destination coordinates, the copy size, surface base offsets, surface pitches, tile flags and a clip corner. Some writes target one field. Others are packed aliases that load two fields from a single 32-bit word, with the fields in different orders. The block masks every field to its legal width and keeps the current parameter set on dedicated outputs for the engine. Any directly addressed register can be read back.

A write that carries the copy width starts a copy. Such a write produces a one-cycle `start_o` pulse in the cycle after the write edge, and the engine sees the new values in that same cycle. If the engine reports busy when such a write arrives, no pulse is issued. A sticky error flag is raised instead and holds until reset. The parameter `VARIANT_B` selects one of two encodings for the offset, pitch and tile fields. Each variant has its own masking for direct writes and its own layout for the packed surface word.

Top module: `blt_param_frontend`

## Requirements
- R1: After synchronous reset every parameter output is zero, `start_o` and `err_o` are low, and every read address returns zero.
- R2: Writes to the single-field registers keep only bits 13:0 of the data. The addresses are 0 src X, 1 src Y, 2 dst X, 3 dst Y, 4 width and 5 height.
- R3: Writes to the Y-then-X aliases (6 source, 8 destination) load X from bits 13:0 and Y from bits 29:16. Writes to the X-then-Y aliases (7 source, 9 destination) load Y from bits 13:0 and X from bits 29:16.
- R4: Writes to the size aliases load two fields each: address 10 loads height from 29:16 and width from 13:0, address 11 loads width from 29:16 and dst X from 13:0, address 12 loads width from 29:16 and height from 13:0, and address 13 loads height from 29:16 and dst Y from 13:0.
- R5: A write to address 4, 10, 11 or 12 while `busy_i` is low drives `start_o` high for the one cycle after the write edge. No other write, including writes to 5 and 13, drives it high.
- R6: A write to address 4, 10, 11 or 12 while `busy_i` is high leaves `start_o` low and sets `err_o`. `err_o` then stays high until reset, while the parameter fields are still updated.
- R7: With `VARIANT_B`=0, direct offset writes (14 src, 16 dst) keep bits 31:4. Direct pitch writes (15 src, 17 dst) keep bits 13:0 as pitch and load the tile flag from bit 16.
- R8: With `VARIANT_B`=1, direct offset writes keep bits 31:10. Direct pitch writes keep bits 13:4 and leave the tile flag unchanged.
- R9: With `VARIANT_B`=0, a packed surface write (18 src, 19 dst) sets offset = bits 20:0 shifted left by 5, pitch = bits 30:21 and tile = bit 31.
- R10: With `VARIANT_B`=1, a packed surface write sets offset = bits 20:0 shifted left by 11 (a 32-bit result), pitch = bits 29:22 placed at pitch bits 13:6, and tile = bit 30.
- R11: A write to address 20 sets the clip right edge from bits 13:0 and the clip bottom edge from bits 29:16.
- R12: Reads of 0-5 and 14-17 return the stored value zero-extended. A pitch read returns the tile flag at bit 16 and the pitch in bits 13:0. A read of 20 returns bottom at 29:16 and right at 13:0. Reads of the aliases and of addresses 21-31 return zero, and writes to 21-31 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 5 | Host write word address |
| wr_data | input | 32 | Host write data |
| rd_addr | input | 5 | Host read word address |
| rd_data | output | 32 | Combinational read data |
| busy_i | input | 1 | Engine busy indication |
| start_o | output | 1 | One-cycle copy start pulse |
| err_o | output | 1 | Sticky start-while-busy flag |
| src_x | output | 14 | Source X |
| src_y | output | 14 | Source Y |
| dst_x | output | 14 | Destination X |
| dst_y | output | 14 | Destination Y |
| width | output | 14 | Copy width |
| height | output | 14 | Copy height |
| src_offset | output | 32 | Source surface offset |
| dst_offset | output | 32 | Destination surface offset |
| src_pitch | output | 14 | Source pitch |
| dst_pitch | output | 14 | Destination pitch |
| src_tile | output | 1 | Source tile flag |
| dst_tile | output | 1 | Destination tile flag |
| clip_right | output | 14 | Clip right edge |
| clip_bottom | output | 14 | Clip bottom edge |

## Verification
A field routed to the wrong slot or left with a wrong mask shows up on the parameter outputs one cycle after the write. It also shows up on `rd_data` as soon as that address is selected, so each write is checked against both views. Trigger decode errors appear on `start_o` in the first cycle after the write. A lost sticky error stays visible on `err_o` through every later write. Both variants are driven from the same bus, which exposes any packed-word swap between them.

// File: rtl/blt_pkg.sv
// Shared constants for the blit parameter front-end.
// Assumes a 32-bit host data word and word addressing.
package blt_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 5;
    localparam int COORD_W = 14;

    localparam logic [ADDR_W-1:0] A_SRC_X     = 5'd0;
    localparam logic [ADDR_W-1:0] A_SRC_Y     = 5'd1;
    localparam logic [ADDR_W-1:0] A_DST_X     = 5'd2;
    localparam logic [ADDR_W-1:0] A_DST_Y     = 5'd3;
    localparam logic [ADDR_W-1:0] A_WIDTH     = 5'd4;
    localparam logic [ADDR_W-1:0] A_HEIGHT    = 5'd5;
    localparam logic [ADDR_W-1:0] A_SRC_YX    = 5'd6;
    localparam logic [ADDR_W-1:0] A_SRC_XY    = 5'd7;
    localparam logic [ADDR_W-1:0] A_DST_YX    = 5'd8;
    localparam logic [ADDR_W-1:0] A_DST_XY    = 5'd9;
    localparam logic [ADDR_W-1:0] A_HGT_WID   = 5'd10;
    localparam logic [ADDR_W-1:0] A_WID_X     = 5'd11;
    localparam logic [ADDR_W-1:0] A_WID_HGT   = 5'd12;
    localparam logic [ADDR_W-1:0] A_HGT_Y     = 5'd13;
    localparam logic [ADDR_W-1:0] A_SRC_OFS   = 5'd14;
    localparam logic [ADDR_W-1:0] A_SRC_PITCH = 5'd15;
    localparam logic [ADDR_W-1:0] A_DST_OFS   = 5'd16;
    localparam logic [ADDR_W-1:0] A_DST_PITCH = 5'd17;
    localparam logic [ADDR_W-1:0] A_SRC_SURF  = 5'd18;
    localparam logic [ADDR_W-1:0] A_DST_SURF  = 5'd19;
    localparam logic [ADDR_W-1:0] A_CLIP      = 5'd20;

    // True for the addresses whose write carries the copy width.
    function automatic logic is_launch(input logic [ADDR_W-1:0] a);
        return (a == A_WIDTH) || (a == A_HGT_WID) ||
               (a == A_WID_X) || (a == A_WID_HGT);
    endfunction
endpackage

// File: rtl/blt_surface_fmt.sv
// Surface field decoder: turns one host data word into offset, pitch
// and tile values for a direct write and for a packed surface write.
// The variant is fixed at elaboration; the outputs are pure logic.
module blt_surface_fmt
    import blt_pkg::*;
#(
    parameter bit VARIANT_B = 1'b0
) (
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  pk_ofs,
    output logic [COORD_W-1:0] pk_pitch,
    output logic               pk_tile,
    output logic [DATA_W-1:0]  dr_ofs,
    output logic [COORD_W-1:0] dr_pitch,
    output logic               dr_tile,
    output logic               dr_tile_we
);
    generate
        if (VARIANT_B) begin : g_var_b
            // Coarse alignment: offsets in 2 KiB units, pitch in 64-byte steps.
            assign pk_ofs     = {wdata[20:0], 11'b0};
            assign pk_pitch   = {wdata[29:22], 6'b0};
            assign pk_tile    = wdata[30];
            assign dr_ofs     = {wdata[31:10], 10'b0};
            assign dr_pitch   = {wdata[13:4], 4'b0};
            assign dr_tile    = 1'b0;
            assign dr_tile_we = 1'b0;
        end else begin : g_var_a
            // Fine alignment: offsets in 32-byte units, 10-bit packed pitch.
            assign pk_ofs     = {6'b0, wdata[20:0], 5'b0};
            assign pk_pitch   = {4'b0, wdata[30:21]};
            assign pk_tile    = wdata[31];
            assign dr_ofs     = {wdata[31:4], 4'b0};
            assign dr_pitch   = wdata[13:0];
            assign dr_tile    = wdata[16];
            assign dr_tile_we = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/blt_trigger.sv
// Launch logic: issues a registered one-cycle start for each width-bearing
// write while the engine is idle, and latches a sticky error when such a
// write arrives while the engine is busy.
module blt_trigger
    import blt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              busy_i,
    output logic              start_o,
    output logic              err_o
);
    logic fire;
    assign fire = wr_en && is_launch(wr_addr);

    // Start pulse register and sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_o <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            start_o <= fire && !busy_i;
            if (fire && busy_i) err_o <= 1'b1;
        end
    end

    a_r5_start_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> $past(wr_en) && $past(is_launch(wr_addr)) && !$past(busy_i));
    a_r5_idle_launch_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !busy_i) |=> start_o);
    a_r6_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && busy_i) |=> (!start_o && err_o));
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);
endmodule

// File: rtl/blt_param_regs.sv
// Parameter store: decodes the write address and loads the selected fields
// from the two 14-bit data slices or from the surface decoder outputs.
// Assumes at most one write per cycle; unmapped addresses are ignored.
module blt_param_regs
    import blt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [COORD_W-1:0] fld_lo,
    input  logic [COORD_W-1:0] fld_hi,
    input  logic [DATA_W-1:0]  pk_ofs,
    input  logic [COORD_W-1:0] pk_pitch,
    input  logic               pk_tile,
    input  logic [DATA_W-1:0]  dr_ofs,
    input  logic [COORD_W-1:0] dr_pitch,
    input  logic               dr_tile,
    input  logic               dr_tile_we,
    output logic [COORD_W-1:0] src_x,
    output logic [COORD_W-1:0] src_y,
    output logic [COORD_W-1:0] dst_x,
    output logic [COORD_W-1:0] dst_y,
    output logic [COORD_W-1:0] width,
    output logic [COORD_W-1:0] height,
    output logic [DATA_W-1:0]  src_offset,
    output logic [DATA_W-1:0]  dst_offset,
    output logic [COORD_W-1:0] src_pitch,
    output logic [COORD_W-1:0] dst_pitch,
    output logic               src_tile,
    output logic               dst_tile,
    output logic [COORD_W-1:0] clip_right,
    output logic [COORD_W-1:0] clip_bottom
);
    // Address-decoded field update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_x <= '0; src_y <= '0; dst_x <= '0; dst_y <= '0;
            width <= '0; height <= '0;
            src_offset <= '0; dst_offset <= '0;
            src_pitch <= '0; dst_pitch <= '0;
            src_tile <= 1'b0; dst_tile <= 1'b0;
            clip_right <= '0; clip_bottom <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_SRC_X:   src_x  <= fld_lo;
                A_SRC_Y:   src_y  <= fld_lo;
                A_DST_X:   dst_x  <= fld_lo;
                A_DST_Y:   dst_y  <= fld_lo;
                A_WIDTH:   width  <= fld_lo;
                A_HEIGHT:  height <= fld_lo;
                A_SRC_YX:  begin src_x <= fld_lo; src_y <= fld_hi; end
                A_SRC_XY:  begin src_y <= fld_lo; src_x <= fld_hi; end
                A_DST_YX:  begin dst_x <= fld_lo; dst_y <= fld_hi; end
                A_DST_XY:  begin dst_y <= fld_lo; dst_x <= fld_hi; end
                A_HGT_WID: begin width <= fld_lo; height <= fld_hi; end
                A_WID_X:   begin dst_x <= fld_lo; width <= fld_hi; end
                A_WID_HGT: begin height <= fld_lo; width <= fld_hi; end
                A_HGT_Y:   begin dst_y <= fld_lo; height <= fld_hi; end
                A_SRC_OFS: src_offset <= dr_ofs;
                A_DST_OFS: dst_offset <= dr_ofs;
                A_SRC_PITCH: begin
                    src_pitch <= dr_pitch;
                    if (dr_tile_we) src_tile <= dr_tile;
                end
                A_DST_PITCH: begin
                    dst_pitch <= dr_pitch;
                    if (dr_tile_we) dst_tile <= dr_tile;
                end
                A_SRC_SURF: begin
                    src_offset <= pk_ofs; src_pitch <= pk_pitch; src_tile <= pk_tile;
                end
                A_DST_SURF: begin
                    dst_offset <= pk_ofs; dst_pitch <= pk_pitch; dst_tile <= pk_tile;
                end
                A_CLIP:    begin clip_right <= fld_lo; clip_bottom <= fld_hi; end
                default: ;
            endcase
        end
    end

    a_r3_dst_xy_order: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_DST_XY) |=>
            (dst_x == $past(fld_hi) && dst_y == $past(fld_lo)));
    a_r4_wid_hgt_order: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_WID_HGT) |=>
            (width == $past(fld_hi) && height == $past(fld_lo)));
    a_r12_unmapped_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr > A_CLIP) |=>
            ($stable(width) && $stable(src_offset) && $stable(dst_offset) &&
             $stable(clip_right) && $stable(dst_x)));
endmodule

// File: rtl/blt_readback.sv
// Read multiplexer: presents a stored field, zero-extended or composed,
// for the selected address. Alias and unmapped addresses read zero.
module blt_readback
    import blt_pkg::*;
(
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic [COORD_W-1:0] src_x,
    input  logic [COORD_W-1:0] src_y,
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    input  logic [COORD_W-1:0] width,
    input  logic [COORD_W-1:0] height,
    input  logic [DATA_W-1:0]  src_offset,
    input  logic [DATA_W-1:0]  dst_offset,
    input  logic [COORD_W-1:0] src_pitch,
    input  logic [COORD_W-1:0] dst_pitch,
    input  logic               src_tile,
    input  logic               dst_tile,
    input  logic [COORD_W-1:0] clip_right,
    input  logic [COORD_W-1:0] clip_bottom,
    output logic [DATA_W-1:0]  rd_data
);
    localparam int PAD_W = DATA_W - COORD_W;
    localparam int GAP_W = 16 - COORD_W;

    // Address-selected read value.
    always_comb begin
        case (rd_addr)
            A_SRC_X:     rd_data = {{PAD_W{1'b0}}, src_x};
            A_SRC_Y:     rd_data = {{PAD_W{1'b0}}, src_y};
            A_DST_X:     rd_data = {{PAD_W{1'b0}}, dst_x};
            A_DST_Y:     rd_data = {{PAD_W{1'b0}}, dst_y};
            A_WIDTH:     rd_data = {{PAD_W{1'b0}}, width};
            A_HEIGHT:    rd_data = {{PAD_W{1'b0}}, height};
            A_SRC_OFS:   rd_data = src_offset;
            A_DST_OFS:   rd_data = dst_offset;
            A_SRC_PITCH: rd_data = {15'b0, src_tile, {GAP_W{1'b0}}, src_pitch};
            A_DST_PITCH: rd_data = {15'b0, dst_tile, {GAP_W{1'b0}}, dst_pitch};
            A_CLIP:      rd_data = {{GAP_W{1'b0}}, clip_bottom, {GAP_W{1'b0}}, clip_right};
            default:     rd_data = '0;
        endcase
    end
endmodule

// File: rtl/blt_param_frontend.sv
// Top of the blit parameter front-end: host write/read port, surface field
// decoding for the selected variant, parameter store and launch logic.
// Assumes single-cycle writes sampled on the rising clock edge.
module blt_param_frontend
    import blt_pkg::*;
#(
    parameter bit VARIANT_B = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               busy_i,
    output logic               start_o,
    output logic               err_o,
    output logic [COORD_W-1:0] src_x,
    output logic [COORD_W-1:0] src_y,
    output logic [COORD_W-1:0] dst_x,
    output logic [COORD_W-1:0] dst_y,
    output logic [COORD_W-1:0] width,
    output logic [COORD_W-1:0] height,
    output logic [DATA_W-1:0]  src_offset,
    output logic [DATA_W-1:0]  dst_offset,
    output logic [COORD_W-1:0] src_pitch,
    output logic [COORD_W-1:0] dst_pitch,
    output logic               src_tile,
    output logic               dst_tile,
    output logic [COORD_W-1:0] clip_right,
    output logic [COORD_W-1:0] clip_bottom
);
    logic [COORD_W-1:0] fld_lo, fld_hi;
    logic [DATA_W-1:0]  pk_ofs, dr_ofs;
    logic [COORD_W-1:0] pk_pitch, dr_pitch;
    logic               pk_tile, dr_tile, dr_tile_we;

    assign fld_lo = wr_data[COORD_W-1:0];
    assign fld_hi = wr_data[16+COORD_W-1:16];

    blt_surface_fmt #(.VARIANT_B(VARIANT_B)) u_fmt (
        .wdata(wr_data), .pk_ofs(pk_ofs), .pk_pitch(pk_pitch), .pk_tile(pk_tile),
        .dr_ofs(dr_ofs), .dr_pitch(dr_pitch), .dr_tile(dr_tile), .dr_tile_we(dr_tile_we)
    );

    blt_param_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .fld_lo(fld_lo), .fld_hi(fld_hi),
        .pk_ofs(pk_ofs), .pk_pitch(pk_pitch), .pk_tile(pk_tile),
        .dr_ofs(dr_ofs), .dr_pitch(dr_pitch), .dr_tile(dr_tile), .dr_tile_we(dr_tile_we),
        .src_x(src_x), .src_y(src_y), .dst_x(dst_x), .dst_y(dst_y),
        .width(width), .height(height),
        .src_offset(src_offset), .dst_offset(dst_offset),
        .src_pitch(src_pitch), .dst_pitch(dst_pitch),
        .src_tile(src_tile), .dst_tile(dst_tile),
        .clip_right(clip_right), .clip_bottom(clip_bottom)
    );

    blt_trigger u_trig (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .busy_i(busy_i), .start_o(start_o), .err_o(err_o)
    );

    blt_readback u_rd (
        .rd_addr(rd_addr),
        .src_x(src_x), .src_y(src_y), .dst_x(dst_x), .dst_y(dst_y),
        .width(width), .height(height),
        .src_offset(src_offset), .dst_offset(dst_offset),
        .src_pitch(src_pitch), .dst_pitch(dst_pitch),
        .src_tile(src_tile), .dst_tile(dst_tile),
        .clip_right(clip_right), .clip_bottom(clip_bottom),
        .rd_data(rd_data)
    );
endmodule

// File: tb/sim_blt_param_frontend.sv
module sim_blt_param_frontend;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0] rd_addr = '0;
    logic busy_i = 1'b0;
    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    logic [31:0] rd0, rd1;
    logic st0, st1, er0, er1;
    logic [13:0] sx0, sy0, dx0, dy0, w0, h0, sp0, dp0, cr0, cb0;
    logic [13:0] sx1, sy1, dx1, dy1, w1, h1, sp1, dp1, cr1, cb1;
    logic [31:0] so0, do0, so1, do1;
    logic stl0, dtl0, stl1, dtl1;

    blt_param_frontend #(.VARIANT_B(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd0), .busy_i(busy_i), .start_o(st0), .err_o(er0),
        .src_x(sx0), .src_y(sy0), .dst_x(dx0), .dst_y(dy0), .width(w0), .height(h0),
        .src_offset(so0), .dst_offset(do0), .src_pitch(sp0), .dst_pitch(dp0),
        .src_tile(stl0), .dst_tile(dtl0), .clip_right(cr0), .clip_bottom(cb0));

    blt_param_frontend #(.VARIANT_B(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd1), .busy_i(busy_i), .start_o(st1), .err_o(er1),
        .src_x(sx1), .src_y(sy1), .dst_x(dx1), .dst_y(dy1), .width(w1), .height(h1),
        .src_offset(so1), .dst_offset(do1), .src_pitch(sp1), .dst_pitch(dp1),
        .src_tile(stl1), .dst_tile(dtl1), .clip_right(cr1), .clip_bottom(cb1));

    // Reference model, index 0 = variant A, 1 = variant B.
    logic [13:0] m_sx[2], m_sy[2], m_dx[2], m_dy[2], m_w[2], m_h[2];
    logic [13:0] m_sp[2], m_dp[2], m_cr[2], m_cb[2];
    logic [31:0] m_so[2], m_do[2];
    logic m_st[2], m_dt[2];
    logic m_err;

    function automatic logic launch(input logic [4:0] a);
        return a == 5'd4 || a == 5'd10 || a == 5'd11 || a == 5'd12;
    endfunction

    function automatic string req_of(input logic [4:0] a, input int v);
        if (a <= 5'd5) return "R2";
        if (a <= 5'd9) return "R3";
        if (a <= 5'd13) return "R4";
        if (a <= 5'd17) return (v == 0) ? "R7" : "R8";
        if (a <= 5'd19) return (v == 0) ? "R9" : "R10";
        if (a == 5'd20) return "R11";
        return "R12";
    endfunction

    task automatic model_reset();
        for (int v = 0; v < 2; v++) begin
            m_sx[v] = 0; m_sy[v] = 0; m_dx[v] = 0; m_dy[v] = 0; m_w[v] = 0; m_h[v] = 0;
            m_sp[v] = 0; m_dp[v] = 0; m_cr[v] = 0; m_cb[v] = 0;
            m_so[v] = 0; m_do[v] = 0; m_st[v] = 0; m_dt[v] = 0;
        end
        m_err = 0;
    endtask

    task automatic model_write(input logic [4:0] a, input logic [31:0] d, input logic b);
        logic [13:0] lo, hi;
        logic [31:0] po, dof;
        logic [13:0] pp, dpi;
        logic pt;
        lo = 14'(d & 32'h3FFF);
        hi = 14'((d >> 16) & 32'h3FFF);
        for (int v = 0; v < 2; v++) begin
            if (v == 0) begin
                po = (d & 32'h001F_FFFF) << 5;
                pp = 14'((d >> 21) & 32'h3FF);
                pt = d[31];
                dof = d & 32'hFFFF_FFF0;
                dpi = 14'(d & 32'h3FFF);
            end else begin
                po = d << 11;
                pp = 14'((d & 32'h3FC0_0000) >> 16);
                pt = d[30];
                dof = d & 32'hFFFF_FC00;
                dpi = 14'(d & 32'h3FF0);
            end
            case (a)
                5'd0: m_sx[v] = lo;
                5'd1: m_sy[v] = lo;
                5'd2: m_dx[v] = lo;
                5'd3: m_dy[v] = lo;
                5'd4: m_w[v] = lo;
                5'd5: m_h[v] = lo;
                5'd6: begin m_sx[v] = lo; m_sy[v] = hi; end
                5'd7: begin m_sy[v] = lo; m_sx[v] = hi; end
                5'd8: begin m_dx[v] = lo; m_dy[v] = hi; end
                5'd9: begin m_dy[v] = lo; m_dx[v] = hi; end
                5'd10: begin m_h[v] = hi; m_w[v] = lo; end
                5'd11: begin m_w[v] = hi; m_dx[v] = lo; end
                5'd12: begin m_w[v] = hi; m_h[v] = lo; end
                5'd13: begin m_h[v] = hi; m_dy[v] = lo; end
                5'd14: m_so[v] = dof;
                5'd16: m_do[v] = dof;
                5'd15: begin m_sp[v] = dpi; if (v == 0) m_st[v] = d[16]; end
                5'd17: begin m_dp[v] = dpi; if (v == 0) m_dt[v] = d[16]; end
                5'd18: begin m_so[v] = po; m_sp[v] = pp; m_st[v] = pt; end
                5'd19: begin m_do[v] = po; m_dp[v] = pp; m_dt[v] = pt; end
                5'd20: begin m_cr[v] = lo; m_cb[v] = hi; end
                default: ;
            endcase
        end
        if (launch(a) && b) m_err = 1;
    endtask

    function automatic logic [31:0] model_read(input int v, input logic [4:0] a);
        case (a)
            5'd0: return 32'(m_sx[v]);
            5'd1: return 32'(m_sy[v]);
            5'd2: return 32'(m_dx[v]);
            5'd3: return 32'(m_dy[v]);
            5'd4: return 32'(m_w[v]);
            5'd5: return 32'(m_h[v]);
            5'd14: return m_so[v];
            5'd16: return m_do[v];
            5'd15: return (32'(m_st[v]) << 16) | 32'(m_sp[v]);
            5'd17: return (32'(m_dt[v]) << 16) | 32'(m_dp[v]);
            5'd20: return (32'(m_cb[v]) << 16) | 32'(m_cr[v]);
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [255:0] model_vec(input int v);
        return {50'b0, m_sx[v], m_sy[v], m_dx[v], m_dy[v], m_w[v], m_h[v], m_so[v], m_do[v],
                m_sp[v], m_dp[v], m_st[v], m_dt[v], m_cr[v], m_cb[v]};
    endfunction

    function automatic logic [255:0] dut_vec(input int v);
        if (v == 0)
            return {50'b0, sx0, sy0, dx0, dy0, w0, h0, so0, do0, sp0, dp0, stl0, dtl0, cr0, cb0};
        return {50'b0, sx1, sy1, dx1, dy1, w1, h1, so1, do1, sp1, dp1, stl1, dtl1, cr1, cb1};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Check all outputs and a read of address ra against the model.
    task automatic check_all(input logic [4:0] ra, input logic exp_start, input string sreq);
        rd_addr = ra;
        #1;
        for (int v = 0; v < 2; v++) begin
            chk(req_of(ra, v), "fields", dut_vec(v), model_vec(v));
            chk((ra <= 5'd5 || ra >= 5'd14) ? "R12" : req_of(ra, v), "readback",
                256'(v == 0 ? rd0 : rd1), 256'(model_read(v, ra)));
        end
        chk(sreq, "start_u0", 256'(st0), 256'(exp_start));
        chk(sreq, "start_u1", 256'(st1), 256'(exp_start));
        chk("R6", "err", 256'({er0, er1}), 256'({m_err, m_err}));
    endtask

    task automatic do_wr(input logic [4:0] a, input logic [31:0] d, input logic b);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; busy_i = b;
        @(negedge clk);
        wr_en = 1'b0; busy_i = 1'b0;
        model_write(a, d, b);
        check_all(a, launch(a) && !b, b ? "R6" : "R5");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state on outputs and on every read address
        for (int a = 0; a < 32; a++) begin
            rd_addr = 5'(a);
            #1;
            chk("R1", "reset read u0", 256'(rd0), 256'(0));
            chk("R1", "reset read u1", 256'(rd1), 256'(0));
        end
        chk("R1", "reset fields u0", dut_vec(0), 256'(0));
        chk("R1", "reset fields u1", dut_vec(1), 256'(0));
        chk("R1", "reset start/err", 256'({st0, st1, er0, er1}), 256'(0));

        // Directed: every address with all-ones and alternating data
        for (int a = 0; a < 32; a++) do_wr(5'(a), 32'hFFFF_FFFF, 1'b0);
        for (int a = 0; a < 32; a++) do_wr(5'(a), 32'h5A5A_A5A5, 1'b0);
        for (int a = 0; a < 32; a++) do_wr(5'(a), 32'hA5A5_5A5A, 1'b0);
        // R3 order check with distinct halves
        do_wr(5'd6, 32'h0123_0456, 1'b0);
        do_wr(5'd7, 32'h0111_0222, 1'b0);
        // R8 tile unchanged in variant B after packed tile set
        do_wr(5'd18, 32'h4000_0000, 1'b0);
        do_wr(5'd15, 32'h0001_0000, 1'b0);
        // R5: pulse lasts one cycle only
        do_wr(5'd4, 32'h0000_0010, 1'b0);
        @(negedge clk);
        chk("R5", "pulse width", 256'({st0, st1}), 256'(0));
        // R5: height-only and height-Y do not launch
        do_wr(5'd5, 32'h0000_0020, 1'b0);
        do_wr(5'd13, 32'h0030_0040, 1'b0);
        // R6: launch while busy, then error stays
        do_wr(5'd12, 32'h0050_0060, 1'b1);
        do_wr(5'd0, 32'h0000_0001, 1'b0);
        do_wr(5'd10, 32'h0007_0008, 1'b0);

        // Constrained random mix
        for (int i = 0; i < 600; i++) begin
            logic [4:0] a;
            a = ($urandom % 8 == 0) ? 5'($urandom % 32) : 5'($urandom % 21);
            do_wr(a, $urandom, ($urandom % 4) == 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R5 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule